// File: doc/BRIEF.md
# Debug-Port Fast Block Transfer Handler

This block lets an external debug probe finish a processor access that is parked on a small debug-memory window. The processor side presents one stalled access: an address, a load/store flag, store data and a pending flag. It waits until the block returns a one-cycle done pulse, plus read data when the access is a load. The debug side receives capture, shift and update strobes from a TAP controller. These strobes count only while the fast-transfer instruction is selected. All strobes are single-cycle enables in the processor clock domain.

The block builds a 33-bit scan chain. A one-bit status flag sits at the least-significant end and is followed by a 32-bit data field. On capture, the flag is loaded with a success indication: 1 only when an access is pending and its address falls inside the 16-byte window that starts at 0xFF20_0000. For a store, the data field is also loaded with the store data so it can be uploaded to the probe. During shift, the probe sends in a request bit and, for a load, the value to return. On update, a request bit of 0 together with a captured success completes the access. Any other combination leaves the processor stalled.

Top module: `fast_xfer_handler`

## Requirements
- R1: After reset, tdo, cpuDone and cpuRdata are all 0.
- R2: The capture after a selected capture strobe sets the flag (the first bit on tdo) to 1 only if cpuPending is 1 and cpuAddr lies in the legal window.
- R3: The legal window is 0xFF20_0000 to 0xFF20_000F inclusive; 0xFF1F_FFFF and 0xFF20_0010 give a flag of 0 and are never completed.
- R4: The chain is 33 bits: bit 0 is the flag and is shifted out first, then data bits 0 to 31. Each shift moves tdi in at bit 32.
- R5: For a load (cpuWrite=0), an update with shifted-in flag 0 and a captured success pulses cpuDone in the next cycle. In that same cycle cpuRdata holds the 32 shifted-in data bits.
- R6: If the shifted-in flag is 1, update gives no cpuDone and cpuRdata keeps its value.
- R7: If the captured flag was 0 (no pending access or illegal address), update gives no cpuDone.
- R8: cpuDone is high for exactly one cycle, and only in the cycle after a selected update.
- R9: Capture, shift and update strobes have no effect while tapSel is 0: tdo, cpuDone and cpuRdata stay unchanged.
- R10: For a store (cpuWrite=1), the captured data field equals cpuWdata, and a successful update pulses cpuDone while cpuRdata keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tapSel | input | 1 | Fast-transfer instruction selected |
| tapCapture | input | 1 | Capture strobe |
| tapShift | input | 1 | Shift strobe |
| tapUpdate | input | 1 | Update strobe |
| tdi | input | 1 | Serial data from probe |
| tdo | output | 1 | Serial data to probe (chain bit 0) |
| cpuPending | input | 1 | Processor access stalled on window |
| cpuAddr | input | 32 | Address of the stalled access |
| cpuWrite | input | 1 | 1 = store, 0 = load |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load return data |
| cpuDone | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties check on every cycle that done only follows a selected update, that it never lasts two cycles, and that it never occurs without a pending access. They also check that the captured flag matches the success condition, that tdo moves only on capture or shift, and that read data changes only on a completing load. The bench scenarios are needed to show the window edges and the exact bit order of the chain. They also show that download data arrives intact, that upload data leaves intact, and that an unselected instruction ignores all strobes.

// File: rtl/fxh_pkg.sv
package fxh_pkg;
  typedef struct packed {
    logic capture;
    logic shift;
    logic complete;
    logic loadStore;
  } fxStrobe_t;
endpackage

// File: rtl/fxh_ctrl.sv
module fxh_ctrl
  import fxh_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_LOG2 = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFF20_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tapSel,
  input  logic              tapCapture,
  input  logic              tapShift,
  input  logic              tapUpdate,
  input  logic              cpuPending,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  input  logic              flagIn,
  output fxStrobe_t         strb,
  output logic              success,
  output logic              cpuDone
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

  logic inWindow;
  logic okQ;
  logic updSel;

  assign inWindow = (cpuAddr[ADDR_W-1:WIN_LOG2] == WIN_TAG);
  assign success  = cpuPending && inWindow;
  assign updSel   = tapSel && tapUpdate && !tapCapture && !tapShift;

  always_comb begin
    strb.capture   = tapSel && tapCapture;
    strb.shift     = tapSel && tapShift && !tapCapture;
    strb.complete  = updSel && !flagIn && okQ;
    strb.loadStore = cpuWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      okQ     <= 1'b0;
      cpuDone <= 1'b0;
    end else begin
      cpuDone <= strb.complete;
      if (strb.capture) okQ <= success;
      else if (updSel)  okQ <= 1'b0;
    end
  end

  p_done_after_update_r8: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> $past(tapSel && tapUpdate));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);
  p_done_needs_pending_r7: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> $past(cpuPending));
endmodule

// File: rtl/fxh_datapath.sv
module fxh_datapath
  import fxh_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  fxStrobe_t         strb,
  input  logic              success,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              tdo,
  output logic              flagOut,
  output logic [DATA_W-1:0] cpuRdata
);
  localparam int CHAIN_W = DATA_W + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain    <= '0;
      cpuRdata <= '0;
    end else begin
      if (strb.capture)
        chain <= {(strb.loadStore ? cpuWdata : {DATA_W{1'b0}}), success};
      else if (strb.shift)
        chain <= {tdi, chain[CHAIN_W-1:1]};
      if (strb.complete && !strb.loadStore)
        cpuRdata <= chain[CHAIN_W-1:1];
    end
  end

  assign tdo     = chain[0];
  assign flagOut = chain[0];

  p_capture_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (tdo == $past(success)));
  p_tdo_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.capture || strb.shift) |=> $stable(tdo));
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.complete |=> $stable(cpuRdata));
endmodule

// File: rtl/fast_xfer_handler.sv
module fast_xfer_handler
  import fxh_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN_LOG2 = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFF20_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tapSel,
  input  logic              tapCapture,
  input  logic              tapShift,
  input  logic              tapUpdate,
  input  logic              tdi,
  output logic              tdo,
  input  logic              cpuPending,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuDone
);
  fxStrobe_t strb;
  logic      success;
  logic      flagOut;

  fxh_ctrl #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .tapSel(tapSel), .tapCapture(tapCapture),
    .tapShift(tapShift), .tapUpdate(tapUpdate), .cpuPending(cpuPending),
    .cpuAddr(cpuAddr), .cpuWrite(cpuWrite), .flagIn(flagOut),
    .strb(strb), .success(success), .cpuDone(cpuDone)
  );

  fxh_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .success(success), .tdi(tdi),
    .cpuWdata(cpuWdata), .tdo(tdo), .flagOut(flagOut), .cpuRdata(cpuRdata)
  );

  p_rdata_only_on_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cpuDone |-> $stable(cpuRdata));
endmodule

// File: tb/tb_fast_xfer_handler.sv
module tb_fast_xfer_handler;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tapSel = 1'b0, tapCapture = 1'b0, tapShift = 1'b0, tapUpdate = 1'b0, tdi = 1'b0;
  logic tdo;
  logic cpuPending = 1'b0, cpuWrite = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic cpuDone;

  int checks = 0;
  int failures = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  fast_xfer_handler dut (
    .clk(clk), .rstN(rstN), .tapSel(tapSel), .tapCapture(tapCapture),
    .tapShift(tapShift), .tapUpdate(tapUpdate), .tdi(tdi), .tdo(tdo),
    .cpuPending(cpuPending), .cpuAddr(cpuAddr), .cpuWrite(cpuWrite),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuDone(cpuDone)
  );

  // behavioural reference: queue of chain bits, front = bit shifted out next
  bit mq[$];
  bit mOk;
  bit mDone;
  logic [31:0] mRdata;

  always @(posedge clk) begin
    if (!rstN) begin
      mq = {};
      for (int i = 0; i < 33; i++) mq.push_back(1'b0);
      mOk = 0; mDone = 0; mRdata = '0;
    end else begin
      mDone = 0;
      if (tapSel && tapCapture) begin
        mOk = cpuPending && (cpuAddr >= 32'hFF20_0000) && (cpuAddr <= 32'hFF20_000F);
        mq = {};
        mq.push_back(mOk);
        for (int i = 0; i < 32; i++) mq.push_back(cpuWrite ? cpuWdata[i] : 1'b0);
      end else if (tapSel && tapShift) begin
        void'(mq.pop_front());
        mq.push_back(tdi);
      end else if (tapSel && tapUpdate) begin
        if (mq[0] == 1'b0 && mOk) begin
          mDone = 1;
          if (!cpuWrite) for (int i = 0; i < 32; i++) mRdata[i] = mq[i+1];
        end
        mOk = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    check(tdo == mq[0], {phase, " tdo model"}, {31'd0, tdo}, {31'd0, mq[0]});
    check(cpuDone == mDone, {phase, " done model"}, {31'd0, cpuDone}, {31'd0, mDone});
    check(cpuRdata == mRdata, {phase, " rdata model"}, cpuRdata, mRdata);
  end

  // one full capture/shift/update pass; returns the 33 bits seen on tdo
  task automatic scan(input bit flagIn, input logic [31:0] dIn,
                      output logic [32:0] seen, output bit doneSeen);
    logic [32:0] tx;
    tx = {dIn, flagIn};
    tapCapture = 1; @(negedge clk);
    tapCapture = 0;
    for (int i = 0; i < 33; i++) begin
      seen[i] = tdo;
      tapShift = 1; tdi = tx[i];
      @(negedge clk);
    end
    tapShift = 0; tapUpdate = 1; @(negedge clk);
    tapUpdate = 0;
    doneSeen = cpuDone;
    @(negedge clk);
    check(cpuDone == 1'b0, "R8 single pulse", {31'd0, cpuDone}, 32'd0);
    if (doneSeen) cpuPending = 0;
  endtask

  logic [32:0] seen;
  bit doneSeen;
  logic [31:0] keep;

  initial begin
    repeat (3) @(negedge clk);
    check(tdo == 0 && cpuDone == 0 && cpuRdata == 0, "R1 reset", cpuRdata, 32'd0);
    rstN = 1; @(negedge clk);
    check(tdo == 0 && cpuDone == 0 && cpuRdata == 0, "R1 after reset", cpuRdata, 32'd0);
    tapSel = 1;

    phase = "R5";
    cpuPending = 1; cpuWrite = 0; cpuAddr = 32'hFF20_0004;
    scan(1'b0, 32'hA5C3_1E0F, seen, doneSeen);
    check(seen[0] == 1, "R2 flag legal pending", {31'd0, seen[0]}, 32'd1);
    check(doneSeen == 1, "R5 done", {31'd0, doneSeen}, 32'd1);
    check(cpuRdata == 32'hA5C3_1E0F, "R5 rdata", cpuRdata, 32'hA5C3_1E0F);

    phase = "R10";
    cpuPending = 1; cpuWrite = 1; cpuAddr = 32'hFF20_000C; cpuWdata = 32'h1234_ABCD;
    keep = cpuRdata;
    scan(1'b0, 32'h0, seen, doneSeen);
    check(seen[32:1] == 32'h1234_ABCD, "R4 R10 upload data", seen[32:1], 32'h1234_ABCD);
    check(doneSeen == 1, "R10 store done", {31'd0, doneSeen}, 32'd1);
    check(cpuRdata == keep, "R10 rdata kept", cpuRdata, keep);

    phase = "R6";
    cpuPending = 1; cpuWrite = 0; cpuAddr = 32'hFF20_0000;
    keep = cpuRdata;
    scan(1'b1, 32'hDEAD_BEEF, seen, doneSeen);
    check(seen[0] == 1, "R3 low edge legal", {31'd0, seen[0]}, 32'd1);
    check(doneSeen == 0, "R6 no done on flag 1", {31'd0, doneSeen}, 32'd0);
    check(cpuRdata == keep, "R6 rdata kept", cpuRdata, keep);

    phase = "R3";
    cpuAddr = 32'hFF20_000F;
    scan(1'b0, 32'h0BAD_F00D, seen, doneSeen);
    check(seen[0] == 1 && doneSeen == 1, "R3 high edge legal", {31'd0, doneSeen}, 32'd1);
    check(cpuRdata == 32'h0BAD_F00D, "R3 R5 rdata", cpuRdata, 32'h0BAD_F00D);

    cpuPending = 1; cpuAddr = 32'hFF20_0010;
    scan(1'b0, 32'h1111_2222, seen, doneSeen);
    check(seen[0] == 0 && doneSeen == 0, "R3 above window", {31'd0, doneSeen}, 32'd0);
    cpuAddr = 32'hFF1F_FFFF;
    scan(1'b0, 32'h3333_4444, seen, doneSeen);
    check(seen[0] == 0 && doneSeen == 0, "R3 below window", {31'd0, doneSeen}, 32'd0);
    check(cpuRdata == 32'h0BAD_F00D, "R7 rdata kept", cpuRdata, 32'h0BAD_F00D);

    phase = "R7";
    cpuPending = 0; cpuAddr = 32'hFF20_0008;
    scan(1'b0, 32'h5555_6666, seen, doneSeen);
    check(seen[0] == 0 && doneSeen == 0, "R7 nothing pending", {31'd0, doneSeen}, 32'd0);

    phase = "R9";
    cpuPending = 1; cpuWrite = 1; cpuWdata = 32'hFFFF_FFFF;
    tapSel = 0;
    tapCapture = 1; @(negedge clk); tapCapture = 0;
    check(tdo == 0, "R9 capture ignored", {31'd0, tdo}, 32'd0);
    tapShift = 1; tdi = 1; @(negedge clk); tapShift = 0;
    check(tdo == 0, "R9 shift ignored", {31'd0, tdo}, 32'd0);
    tapUpdate = 1; @(negedge clk); tapUpdate = 0;
    check(cpuDone == 0 && cpuRdata == 32'h0BAD_F00D, "R9 update ignored", cpuRdata, 32'h0BAD_F00D);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule